// File: doc/BRIEF.md
# Extension Instruction Hook Unit

This unit sits at the issue slot of an in-order pipelined processor. It lets an optional extension layer, stacked on or attached to the base core, take over a block of opcodes that the base control logic reserves. The base core decodes each reserved opcode explicitly as an operation that does nothing: it makes no register write and no memory access. The hook watches the opcode and the register specifiers of each issued instruction without altering the base decode path. When a reserved opcode arrives and the layer is present, the hook offers the instruction to the layer. The offer carries the two source operand values.

The layer accepts the offer by raising a claim in that same cycle. If the layer also raises its done pulse in that cycle, the instruction retires at once. If not, the hook holds the pipeline and keeps a copy of the operands until the done pulse arrives. On retirement the layer's result takes the place of the normal writeback data through a widened writeback multiplexer. This happens only when the result is flagged valid and the destination is not register zero. A reserved opcode that no layer claims is simply a no-operation. With the presence input low, the hook forces offer, stall and override inactive.

Top module: `ehk_hook`

## Requirements
- R1: `rsv_hit` is high exactly when `iss_valid` is high and `iss_opcode` lies in the inclusive range RSV_LO..RSV_HI (defaults 0x38..0x3B). Opcodes 0x37 and 0x3C are outside the range.
- R2: `mem_en` equals `host_mem_en` with any reserved opcode masked out, so a reserved instruction never reaches memory.
- R3: A reserved instruction that is not claimed produces no register write: `wb_en` is low in the cycle after it issues.
- R4: `ext_req` is high when the instruction is valid and reserved, the layer is present and no claimed instruction is pending. While no instruction is pending, `ext_opcode`, `ext_src_a`, `ext_src_b`, `ext_dst`, `ext_op_a` and `ext_op_b` show the live issue fields.
- R5: When an instruction is claimed without a same-cycle done, `pipe_hold` is high from the claim cycle up to, but not including, the cycle in which `ext_done` is high. During that wait `ext_req` stays low and the forwarded fields keep the values captured at the claim, even if the issue inputs change.
- R6: When a claimed instruction retires with `ext_res_valid` high and a nonzero destination, the next cycle shows `wb_en`=1, `wb_addr` equal to the claimed destination and `wb_data` equal to `ext_res_data`.
- R7: When a claimed instruction retires with `ext_res_valid` low, or with destination 0, the next cycle shows `wb_en`=0.
- R8: With `layer_present` low, `ext_req` and `pipe_hold` are low and no result is written. Lowering it during a wait ends the wait in that cycle, without a write.
- R9: For a valid non-reserved instruction with no pending claim, the next cycle shows `wb_en` equal to `host_wr_en`, `wb_addr` equal to `iss_dst` and `wb_data` equal to `host_wr_data`.
- R10: During reset, `pipe_hold` and `wb_en` are low.
- R11: A claim and a done in the same cycle leave `pipe_hold` low and write the result in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layer_present | input | 1 | Extension layer attached and active |
| iss_valid | input | 1 | Issue slot holds a valid instruction |
| iss_opcode | input | OPC_W | Opcode of the issued instruction |
| iss_src_a | input | REG_AW | First source register specifier |
| iss_src_b | input | REG_AW | Second source register specifier |
| iss_dst | input | REG_AW | Destination register specifier |
| iss_val_a | input | DATA_W | First source operand value |
| iss_val_b | input | DATA_W | Second source operand value |
| host_wr_en | input | 1 | Base datapath wants to write a register |
| host_wr_data | input | DATA_W | Base datapath writeback value |
| host_mem_en | input | 1 | Base datapath wants a memory access |
| ext_claim | input | 1 | Layer accepts the offered instruction |
| ext_done | input | 1 | Layer finishes the claimed instruction |
| ext_res_valid | input | 1 | Layer result is to be written |
| ext_res_data | input | DATA_W | Layer result value |
| rsv_hit | output | 1 | Issued opcode is in the reserved range |
| mem_en | output | 1 | Memory access enable after masking |
| ext_req | output | 1 | Offer of a reserved instruction to the layer |
| ext_opcode | output | OPC_W | Forwarded opcode |
| ext_src_a | output | REG_AW | Forwarded first source specifier |
| ext_src_b | output | REG_AW | Forwarded second source specifier |
| ext_dst | output | REG_AW | Forwarded destination specifier |
| ext_op_a | output | DATA_W | Forwarded first operand value |
| ext_op_b | output | DATA_W | Forwarded second operand value |
| pipe_hold | output | 1 | Stall the issue, execute and fetch registers |
| wb_en | output | 1 | Registered writeback enable |
| wb_addr | output | REG_AW | Registered writeback register |
| wb_data | output | DATA_W | Registered writeback value |

## Verification
The hardest case to reach is a wait that ends some other way than the plain done pulse. One example is the presence input dropping while a claim is pending. Another is a done that arrives while the issue inputs have already moved on, which shows whether the forwarded operands and the destination come from the captured copy. Directed sequences first hold a claim for several cycles while the operand and destination inputs change, then abort one wait by lowering presence. Fixed-seed random stimulus follows. It mixes present and absent layers, claims, done pulses at random delays, destination zero and opcodes just inside and just outside the range.

// File: rtl/ehk_pkg.sv
package ehk_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ehk_state_e;
endpackage

// File: rtl/ehk_range_decode.sv
module ehk_range_decode #(
    parameter int OPC_W = 6,
    parameter int LO    = 56,
    parameter int HI    = 59
) (
    input  logic             valid,
    input  logic [OPC_W-1:0] opcode,
    output logic             hit
);
    localparam logic [OPC_W-1:0] LO_C = OPC_W'(LO);
    localparam logic [OPC_W-1:0] HI_C = OPC_W'(HI);

    always_comb begin
        hit = valid && (opcode >= LO_C) && (opcode <= HI_C);
    end
endmodule

// File: rtl/ehk_wb_select.sv
module ehk_wb_select #(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic              ext_wr,
    input  logic              host_wr,
    input  logic [REG_AW-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    output logic              sel_en,
    output logic [REG_AW-1:0] sel_addr,
    output logic [DATA_W-1:0] sel_data
);
    // Widened writeback mux: layer result wins, host path second, else idle.
    always_comb begin
        sel_en   = 1'b0;
        sel_addr = '0;
        sel_data = '0;
        if (ext_wr) begin
            sel_en   = 1'b1;
            sel_addr = ext_addr;
            sel_data = ext_data;
        end else if (host_wr) begin
            sel_en   = 1'b1;
            sel_addr = host_addr;
            sel_data = host_data;
        end
    end
endmodule

// File: rtl/ehk_hook.sv
module ehk_hook
    import ehk_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int REG_AW = 5,
    parameter int DATA_W = 32,
    parameter int RSV_LO = 56,
    parameter int RSV_HI = 59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              layer_present,
    input  logic              iss_valid,
    input  logic [OPC_W-1:0]  iss_opcode,
    input  logic [REG_AW-1:0] iss_src_a,
    input  logic [REG_AW-1:0] iss_src_b,
    input  logic [REG_AW-1:0] iss_dst,
    input  logic [DATA_W-1:0] iss_val_a,
    input  logic [DATA_W-1:0] iss_val_b,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              host_mem_en,
    input  logic              ext_claim,
    input  logic              ext_done,
    input  logic              ext_res_valid,
    input  logic [DATA_W-1:0] ext_res_data,
    output logic              rsv_hit,
    output logic              mem_en,
    output logic              ext_req,
    output logic [OPC_W-1:0]  ext_opcode,
    output logic [REG_AW-1:0] ext_src_a,
    output logic [REG_AW-1:0] ext_src_b,
    output logic [REG_AW-1:0] ext_dst,
    output logic [DATA_W-1:0] ext_op_a,
    output logic [DATA_W-1:0] ext_op_b,
    output logic              pipe_hold,
    output logic              wb_en,
    output logic [REG_AW-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    typedef struct packed {
        ehk_state_e        state;
        logic [OPC_W-1:0]  opc;
        logic [REG_AW-1:0] sa;
        logic [REG_AW-1:0] sb;
        logic [REG_AW-1:0] dst;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              wb_en;
        logic [REG_AW-1:0] wb_addr;
        logic [DATA_W-1:0] wb_data;
    } hook_regs_t;

    hook_regs_t r_d, r_q;

    logic              idle, offer, take, active, retire;
    logic              ext_wr, host_wr;
    logic [REG_AW-1:0] dst_sel;
    logic              sel_en;
    logic [REG_AW-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;

    ehk_range_decode #(.OPC_W(OPC_W), .LO(RSV_LO), .HI(RSV_HI)) u_dec (
        .valid  (iss_valid),
        .opcode (iss_opcode),
        .hit    (rsv_hit)
    );

    ehk_wb_select #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_wb (
        .ext_wr    (ext_wr),
        .host_wr   (host_wr),
        .ext_addr  (dst_sel),
        .ext_data  (ext_res_data),
        .host_addr (iss_dst),
        .host_data (host_wr_data),
        .sel_en    (sel_en),
        .sel_addr  (sel_addr),
        .sel_data  (sel_data)
    );

    always_comb begin
        idle    = (r_q.state == ST_IDLE);
        offer   = rsv_hit && layer_present && idle;
        take    = offer && ext_claim;
        active  = layer_present && (take || !idle);
        retire  = active && ext_done;
        dst_sel = idle ? iss_dst : r_q.dst;
        ext_wr  = retire && ext_res_valid && (dst_sel != ZERO_REG);
        host_wr = idle && iss_valid && !rsv_hit && host_wr_en;

        mem_en     = host_mem_en && !rsv_hit;
        ext_req    = offer;
        pipe_hold  = active && !ext_done;
        ext_opcode = idle ? iss_opcode : r_q.opc;
        ext_src_a  = idle ? iss_src_a  : r_q.sa;
        ext_src_b  = idle ? iss_src_b  : r_q.sb;
        ext_dst    = dst_sel;
        ext_op_a   = idle ? iss_val_a  : r_q.a;
        ext_op_b   = idle ? iss_val_b  : r_q.b;

        r_d         = r_q;
        r_d.state   = pipe_hold ? ST_WAIT : ST_IDLE;
        if (take) begin
            r_d.opc = iss_opcode;
            r_d.sa  = iss_src_a;
            r_d.sb  = iss_src_b;
            r_d.dst = iss_dst;
            r_d.a   = iss_val_a;
            r_d.b   = iss_val_b;
        end
        r_d.wb_en   = sel_en;
        r_d.wb_addr = sel_addr;
        r_d.wb_data = sel_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wb_en   = r_q.wb_en;
    assign wb_addr = r_q.wb_addr;
    assign wb_data = r_q.wb_data;

    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_hit |-> iss_valid);

    a_r2_reserved_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_hit |-> !mem_en);

    a_r3_unclaimed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_claim) |=> !wb_en);

    a_r5_no_offer_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pipe_hold) |-> !ext_req);

    a_r5_ops_stable_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pipe_hold) && pipe_hold) |-> ($stable(ext_op_a) && $stable(ext_op_b) && $stable(ext_dst)));

    a_r6_result_written: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pipe_hold) && layer_present && ext_done && ext_res_valid && ext_dst != ZERO_REG)
        |=> (wb_en && wb_data == $past(ext_res_data) && wb_addr == $past(ext_dst)));

    a_r8_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !layer_present |-> (!ext_req && !pipe_hold));
endmodule

// File: tb/sim_ehk_hook.sv
module sim_ehk_hook;
    localparam int OPC_W  = 6;
    localparam int REG_AW = 5;
    localparam int DATA_W = 32;
    localparam int LO     = 56;
    localparam int HI     = 59;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              layer_present = 1'b0;
    logic              iss_valid = 1'b0;
    logic [OPC_W-1:0]  iss_opcode = '0;
    logic [REG_AW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [DATA_W-1:0] iss_val_a = '0, iss_val_b = '0;
    logic              host_wr_en = 1'b0;
    logic [DATA_W-1:0] host_wr_data = '0;
    logic              host_mem_en = 1'b0;
    logic              ext_claim = 1'b0, ext_done = 1'b0, ext_res_valid = 1'b0;
    logic [DATA_W-1:0] ext_res_data = '0;
    logic              rsv_hit, mem_en, ext_req, pipe_hold, wb_en;
    logic [OPC_W-1:0]  ext_opcode;
    logic [REG_AW-1:0] ext_src_a, ext_src_b, ext_dst, wb_addr;
    logic [DATA_W-1:0] ext_op_a, ext_op_b, wb_data;

    int nchk = 0;
    int nerr = 0;

    // bench model state
    bit                m_wait = 1'b0;
    logic [REG_AW-1:0] m_dst = '0;
    logic [DATA_W-1:0] m_a = '0, m_b = '0;

    always #10 clk = ~clk;

    ehk_hook u0 (
        .clk(clk), .rst_n(rst_n), .layer_present(layer_present),
        .iss_valid(iss_valid), .iss_opcode(iss_opcode),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .iss_val_a(iss_val_a), .iss_val_b(iss_val_b),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_mem_en(host_mem_en),
        .ext_claim(ext_claim), .ext_done(ext_done), .ext_res_valid(ext_res_valid),
        .ext_res_data(ext_res_data),
        .rsv_hit(rsv_hit), .mem_en(mem_en), .ext_req(ext_req),
        .ext_opcode(ext_opcode), .ext_src_a(ext_src_a), .ext_src_b(ext_src_b),
        .ext_dst(ext_dst), .ext_op_a(ext_op_a), .ext_op_b(ext_op_b),
        .pipe_hold(pipe_hold), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit in_range(input logic v, input logic [OPC_W-1:0] op);
        return v && (int'(op) >= LO) && (int'(op) <= HI);
    endfunction

    // Called just after inputs change at a falling edge; returns at the next falling edge.
    task automatic step();
        bit rsv, offer, take, active, retire, hold, ew, hw, zero_lat;
        logic [REG_AW-1:0] dsel;
        logic [DATA_W-1:0] ea, eb;
        bit e_en;
        logic [REG_AW-1:0] e_addr;
        logic [DATA_W-1:0] e_data;
        string wtag;
        #2;
        rsv    = in_range(iss_valid, iss_opcode);
        offer  = rsv && layer_present && !m_wait;
        take   = offer && ext_claim;
        active = layer_present && (take || m_wait);
        retire = active && ext_done;
        hold   = active && !ext_done;
        zero_lat = take && ext_done;
        dsel   = m_wait ? m_dst : iss_dst;
        ea     = m_wait ? m_a : iss_val_a;
        eb     = m_wait ? m_b : iss_val_b;
        ew     = retire && ext_res_valid && (dsel != '0);
        hw     = !m_wait && iss_valid && !rsv && host_wr_en;

        chk("R1 rsv_hit", 64'(rsv_hit), 64'(rsv));
        chk("R2 mem_en", 64'(mem_en), 64'(host_mem_en && !rsv));
        chk(layer_present ? "R4 ext_req" : "R8 ext_req", 64'(ext_req), 64'(offer));
        chk(!layer_present ? "R8 pipe_hold" : (zero_lat ? "R11 pipe_hold" : "R5 pipe_hold"),
            64'(pipe_hold), 64'(hold));
        if (offer || m_wait) begin
            chk(m_wait ? "R5 ext_op_a" : "R4 ext_op_a", 64'(ext_op_a), 64'(ea));
            chk(m_wait ? "R5 ext_op_b" : "R4 ext_op_b", 64'(ext_op_b), 64'(eb));
            chk(m_wait ? "R5 ext_dst" : "R4 ext_dst", 64'(ext_dst), 64'(dsel));
        end

        e_en = ew || hw;
        e_addr = ew ? dsel : iss_dst;
        e_data = ew ? ext_res_data : host_wr_data;
        if (ew) wtag = zero_lat ? "R11 wb" : "R6 wb";
        else if (retire) wtag = "R7 wb";
        else if (m_wait && !layer_present) wtag = "R8 wb";
        else if (rsv) wtag = "R3 wb";
        else wtag = "R9 wb";

        if (take) begin
            m_dst = iss_dst; m_a = iss_val_a; m_b = iss_val_b;
        end
        m_wait = hold;

        @(posedge clk);
        #2;
        chk(wtag, 64'(wb_en), 64'(e_en));
        if (e_en) begin
            chk(wtag, 64'(wb_addr), 64'(e_addr));
            chk(wtag, 64'(wb_data), 64'(e_data));
        end
        @(negedge clk);
    endtask

    task automatic put(input bit v, input int op, input int dst, input bit claim,
                       input bit done, input bit rv);
        iss_valid     = v;
        iss_opcode    = OPC_W'(op);
        iss_dst       = REG_AW'(dst);
        iss_src_a     = REG_AW'($urandom);
        iss_src_b     = REG_AW'($urandom);
        iss_val_a     = $urandom;
        iss_val_b     = $urandom;
        host_wr_data  = $urandom;
        host_wr_en    = 1'b1;
        host_mem_en   = 1'b1;
        ext_claim     = claim;
        ext_done      = done;
        ext_res_valid = rv;
        ext_res_data  = $urandom;
    endtask

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 wb_en", 64'(wb_en), 64'd0);
        chk("R10 pipe_hold", 64'(pipe_hold), 64'd0);
        rst_n = 1'b1;
        layer_present = 1'b1;

        // R1 boundaries, unclaimed reserved (R3)
        put(1, LO - 1, 3, 1, 1, 1); step();
        put(1, LO,     3, 0, 0, 1); step();
        put(1, HI,     4, 0, 0, 1); step();
        put(1, HI + 1, 5, 1, 1, 1); step();
        put(0, LO,     5, 1, 1, 1); step();
        // R11 zero latency
        put(1, LO + 1, 7, 1, 1, 1); step();
        // R5/R6 multi-cycle wait with changing inputs
        put(1, LO + 2, 9, 1, 0, 1); step();
        for (int i = 0; i < 3; i++) begin
            put(1, $urandom % 64, $urandom % 32, $urandom % 2, 0, 1); step();
        end
        put(1, 0, 0, 0, 1, 1); step();
        // R7 no valid result, and destination zero
        put(1, LO, 6, 1, 0, 1); step();
        put(1, LO, 6, 0, 1, 0); step();
        put(1, HI, 0, 1, 1, 1); step();
        // R8 absent layer and abort mid-wait
        layer_present = 1'b0;
        put(1, LO, 8, 1, 1, 1); step();
        layer_present = 1'b1;
        put(1, LO, 8, 1, 0, 1); step();
        put(1, LO, 8, 1, 0, 1); step();
        layer_present = 1'b0;
        put(1, LO, 8, 1, 1, 1); step();
        layer_present = 1'b1;
        put(1, 5, 2, 0, 0, 0); step();

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int sel, op;
            layer_present = ($urandom % 10) != 0;
            sel = $urandom % 4;
            if (sel < 2) op = LO + int'($urandom % (HI - LO + 1));
            else if (sel == 2) op = ($urandom % 2) ? LO - 1 : HI + 1;
            else op = $urandom % 64;
            put(($urandom % 4) != 0, op, ($urandom % 4 == 0) ? 0 : int'($urandom % 32),
                ($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 5) != 0);
            host_wr_en  = $urandom % 2;
            host_mem_en = $urandom % 2;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule